// File: doc/BRIEF.md
# Four-channel event record packer

The block watches four event-change inputs and turns each change into a packed 32-bit log record. The 2-bit number of the channel that changed fills the top two record bits. The low 30 bits of a free-running seconds count, sampled when the event is accepted, fill the rest. Channel 0 is change bit 0 and channel 3 is change bit 3. On the board, channel 3 is wired to port pin 7.

Each record leaves the block as four byte writes on a valid/ready byte port. Every byte carries its own store address. A write-address counter walks the store from address 0 and raises a sticky full flag when another record no longer fits. The default store holds 8192 bytes, which is more than the 2000 records (8000 bytes) the logger has to keep.

A change that arrives while a record is still being sent is held pending. So is a change that arrives together with others. Pending changes are served lowest channel first, one record per channel.

Top module: `evt_rec_packer`

## Requirements
- R1: After reset, byte_valid_o, busy_o and full_o are 0 and byte_addr_o is 0.
- R2: A record is {channel[1:0], secs_i[29:0]}, with channel i meaning change bit i. The two upper seconds bits are discarded, and secs_i is taken in the cycle the event is accepted.
- R3: The four record bytes go out most significant first, one per cycle in which byte_valid_o and byte_ready_i are both 1. While byte_valid_o is 1 and byte_ready_i is 0, byte_data_o and byte_addr_o hold their values.
- R4: byte_addr_o starts at 0 and rises by one after every accepted byte, so consecutive records occupy consecutive 4-byte slots.
- R5: When several change bits are set in one cycle, one record is made per channel, in ascending channel order.
- R6: A change seen while idle is accepted in that cycle. busy_o and byte_valid_o rise on the next edge and fall after the fourth byte is accepted. Changes seen while busy are held and logged afterwards.
- R7: A change on a channel that is already pending is merged into the single pending record for that channel.
- R8: full_o rises once fewer than 4 bytes of the store remain and then stays high. While it is high, every change is dropped and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_i | input | N_CH | Per-channel change pulses, bit i = channel i |
| secs_i | input | TS_W | Free-running seconds count |
| byte_valid_o | output | 1 | A record byte is offered |
| byte_ready_i | input | 1 | Store accepts the offered byte |
| byte_data_o | output | 8 | Record byte, most significant first |
| byte_addr_o | output | ADDR_W | Store address of the offered byte |
| busy_o | output | 1 | A record is being sent |
| full_o | output | 1 | Store cannot take another record |

## Verification
The bench builds the block with a 64-byte store. That gives a capacity of 16 records, so the full flag is reached after the ordinary scenarios plus a few filler events. At that point the bench can check that a burst on all four channels is dropped. The stalled-ready pattern and the multi-channel bursts both run against this small store. The address wrap and the full threshold are therefore exercised with the same arithmetic the 8192-byte default uses.

// File: rtl/evt_rec_pkg.sv
package evt_rec_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned REC_BYTES = 4;
  localparam int unsigned REC_W     = BYTE_W * REC_BYTES;
endpackage

// File: rtl/evt_pend_arb.sv
// Holds change requests and grants the lowest pending channel.
module evt_pend_arb #(
  parameter int unsigned N_CH = 4,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] chg_i,
  input  logic            take_i,
  input  logic            drop_i,
  output logic            req_o,
  output logic [CH_W-1:0] ch_o
);
  logic [N_CH-1:0] pend_q, pend_all, grant;

  assign pend_all = pend_q | chg_i;
  assign req_o    = |pend_all;

  always_comb begin
    grant = '0;
    ch_o  = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_all[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        ch_o     = CH_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (drop_i)  pend_q <= '0;
    else if (take_i)  pend_q <= pend_all & ~grant;
    else              pend_q <= pend_all;
  end
endmodule

// File: rtl/rec_shifter.sv
// Streams a loaded record out as bytes, top byte first.
module rec_shifter
  import evt_rec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              hs_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned IDX_W = $clog2(REC_BYTES);

  logic [REC_W-1:0] rec_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic             last;

  assign valid_o = valid_q;
  assign hs_o    = valid_q & ready_i;
  assign data_o  = rec_q[REC_W-1 -: BYTE_W];
  assign last    = (idx_q == IDX_W'(REC_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      rec_q   <= rec_i;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else if (hs_o) begin
      rec_q   <= rec_q << BYTE_W;
      idx_q   <= idx_q + 1'b1;
      if (last) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wr_addr_ctr.sv
// Byte write address and store-full detection.
module wr_addr_ctr
  import evt_rec_pkg::*;
#(
  parameter int unsigned STORE_BYTES = 8192,
  localparam int unsigned ADDR_W = $clog2(STORE_BYTES),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] LAST_START = CNT_W'(STORE_BYTES - REC_BYTES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign addr_o = cnt_q[ADDR_W-1:0];
  assign full_o = (cnt_q > LAST_START);
endmodule

// File: rtl/evt_rec_packer.sv
module evt_rec_packer
  import evt_rec_pkg::*;
#(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned TS_W        = 32,
  parameter int unsigned STORE_BYTES = 8192,
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned TS_KEEP = REC_W - CH_W,
  localparam int unsigned ADDR_W = $clog2(STORE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   chg_i,
  input  logic [TS_W-1:0]   secs_i,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              busy_o,
  output logic              full_o
);
  logic             req, take, hs, full;
  logic [CH_W-1:0]  ch;
  logic [REC_W-1:0] rec;

  evt_pend_arb #(.N_CH(N_CH)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg_i),
    .take_i (take),
    .drop_i (full),
    .req_o  (req),
    .ch_o   (ch)
  );

  // busy_o doubles as the "record in flight" state
  assign take = req & ~busy_o & ~full;
  assign rec  = {ch, secs_i[TS_KEEP-1:0]};

  rec_shifter i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .rec_i   (rec),
    .ready_i (byte_ready_i),
    .valid_o (busy_o),
    .hs_o    (hs),
    .data_o  (byte_data_o)
  );

  wr_addr_ctr #(.STORE_BYTES(STORE_BYTES)) i_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hs),
    .addr_o (byte_addr_o),
    .full_o (full)
  );

  assign byte_valid_o = busy_o;
  assign full_o       = full;
endmodule

// File: rtl/evt_rec_packer_chk.sv
module evt_rec_packer_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_o,
  input logic              byte_ready_i,
  input logic [7:0]        byte_data_o,
  input logic [ADDR_W-1:0] byte_addr_o,
  input logic              busy_o,
  input logic              full_o
);
  assert_hold_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o) && $stable(byte_addr_o));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && byte_ready_i |=> byte_addr_o == $past(byte_addr_o) + 1'b1);

  assert_addr_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && byte_ready_i) |=> $stable(byte_addr_o));

  assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(byte_valid_o && byte_ready_i));

  assert_full_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);

  assert_full_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !busy_o |=> !byte_valid_o);
endmodule

bind evt_rec_packer evt_rec_packer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_o (byte_valid_o),
  .byte_ready_i (byte_ready_i),
  .byte_data_o  (byte_data_o),
  .byte_addr_o  (byte_addr_o),
  .busy_o       (busy_o),
  .full_o       (full_o)
);

// File: tb/test_evt_rec_packer.sv
module test_evt_rec_packer;
  localparam int unsigned STORE  = 64;
  localparam int unsigned ADDR_W = $clog2(STORE);
  localparam int unsigned N_REC  = STORE / 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        chg_i = '0;
  logic [31:0]       secs_i = '0;
  logic              byte_valid_o;
  logic              byte_ready_i = 1'b0;
  logic [7:0]        byte_data_o;
  logic [ADDR_W-1:0] byte_addr_o;
  logic              busy_o;
  logic              full_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_addr = 0;
  int exp_recs = 0;
  int cyc = 0;
  bit stall_on = 1'b1;
  logic [ADDR_W+7:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  evt_rec_packer #(.N_CH(4), .TS_W(32), .STORE_BYTES(STORE)) i_evt_rec_packer (
    .clk_i, .rst_ni, .chg_i, .secs_i, .byte_valid_o, .byte_ready_i,
    .byte_data_o, .byte_addr_o, .busy_o, .full_o
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Expected record: channel in top two bits, low 30 seconds bits below (R2)
  task automatic push_rec(input int ch, input logic [31:0] secs);
    logic [31:0] rec;
    rec = {ch[1:0], secs[29:0]};
    for (int b = 3; b >= 0; b--) begin
      exp_q.push_back({ADDR_W'(exp_addr), rec[b*8 +: 8]});
      exp_addr++;
    end
    exp_recs++;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk_i); chg_i = m;
    @(negedge clk_i); chg_i = '0;
  endtask

  task automatic drain();
    do @(negedge clk_i); while (exp_q.size() != 0 || busy_o);
    repeat (2) @(negedge clk_i);
  endtask

  // Monitor / ready driver
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      byte_ready_i = rst_ni && !(stall_on && (cyc % 3 == 2));
      if (byte_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8/R7 unexpected byte", int'({byte_addr_o, byte_data_o}), 0);
        end else begin
          check({byte_addr_o, byte_data_o} == exp_q[0], "R2/R3/R4/R5 record byte",
                int'({byte_addr_o, byte_data_o}), int'(exp_q[0]));
          if (byte_ready_i) void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    while (cyc < 60000) @(negedge clk_i);
    check(1'b0, "watchdog", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!byte_valid_o && !busy_o && !full_o && byte_addr_o == 0, "R1 reset state",
          int'({byte_valid_o, busy_o, full_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 top seconds bits dropped, channel 0
    secs_i = 32'hC000_0001;
    push_rec(0, secs_i);
    @(negedge clk_i); chg_i = 4'b0001;
    @(negedge clk_i); chg_i = '0;
    check(busy_o && byte_valid_o, "R6 busy after accept", int'(busy_o), 1);
    drain();
    check(!busy_o, "R6 busy cleared", int'(busy_o), 0);

    // R2 channel 3, all-ones seconds
    secs_i = 32'hFFFF_FFFF;
    push_rec(3, secs_i);
    pulse(4'b1000);
    drain();

    // R5 several channels at once: ascending order
    secs_i = 32'h1234_5678;
    push_rec(0, secs_i); push_rec(1, secs_i); push_rec(3, secs_i);
    pulse(4'b1011);
    drain();

    // R6 change arriving while busy is held
    secs_i = 32'h0ABC_DEF0;
    push_rec(2, secs_i); push_rec(0, secs_i);
    pulse(4'b0100);
    check(busy_o, "R6 busy during record", int'(busy_o), 1);
    pulse(4'b0001);
    drain();

    // R7 repeated change on a pending channel merges
    stall_on = 1'b0;
    secs_i = 32'h2222_3333;
    push_rec(3, secs_i); push_rec(1, secs_i);
    pulse(4'b1000);
    pulse(4'b0010);
    pulse(4'b0010);
    drain();
    stall_on = 1'b1;

    // R8 fill the store
    check(!full_o, "R8 not yet full", int'(full_o), 0);
    for (int k = 0; exp_recs < N_REC; k++) begin
      check(!full_o, "R8 full too early", int'(full_o), 0);
      secs_i = 32'h0100_0000 + 32'(k);
      push_rec(k % 4, secs_i);
      pulse(4'(1 << (k % 4)));
      drain();
    end
    check(full_o, "R8 full raised", int'(full_o), 1);
    check(byte_addr_o == 0, "R4 address after last byte", int'(byte_addr_o), 0);
    pulse(4'b1111);
    repeat (20) @(negedge clk_i);
    check(!byte_valid_o && !busy_o && full_o, "R8 changes dropped when full",
          int'({byte_valid_o, busy_o, full_o}), 1);
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule